// File: doc/BRIEF.md
# Register Window Pointer Controller

This block keeps the current window pointer and the window invalid mask for a processor whose register file is divided into a parameterised number of overlapping windows. Each cycle it may take one command: move down one window (save), move up one window (restore), return from a trap, write the status word, or write the invalid mask. A move goes round the ring of windows in both directions. It is refused when the target window is marked invalid in the mask.

The block also holds the rest of the processor status word: condition codes, FPU enable, interrupt level, supervisor, previous supervisor and trap enable. It presents the packed word on a read port at all times. A refused or illegal command leaves all state as it was. The block then pulses a trap strobe with a two-bit cause code, one cycle after the command. Register storage and trap vectoring are left to the surrounding core.

Top module: `win_ptr_ctrl`

## Requirements
- R1: After reset, the pointer is 0, the mask is 0, trap enable is 0, supervisor is 1, all other status fields are 0 and trap_valid is 0. The status read then equals {VERSION, 24'h000080}.
- R2: A save (cmd_op 1) that is not blocked sets the pointer to pointer-1. From pointer 0 it wraps to NWIN-1.
- R3: A restore (cmd_op 2) that is not blocked sets the pointer to pointer+1. From NWIN-1 it wraps to 0.
- R4: If the mask bit indexed by the target pointer is set, a save traps with code 1 (overflow), a restore traps with code 2 (underflow), and the pointer is unchanged.
- R5: A trap return (cmd_op 3) while trap enable is 1 traps with code 3 (illegal) and changes no state.
- R6: A trap return while trap enable is 0 sets trap enable, moves the pointer up one window as a restore does, and copies previous-supervisor into supervisor. If the target window is masked, it traps with code 2 instead and changes no state.
- R7: A status write (cmd_op 4) whose bits 4:0 are NWIN or greater traps with code 3 and changes no state. Otherwise it loads the condition codes, FPU enable, interrupt level, supervisor, previous supervisor, trap enable and pointer from the written word.
- R8: The status read packs the fields as follows: VERSION at 31:24, condition codes at 23:20, FPU enable at 12, interrupt level at 11:8, supervisor at 7, previous supervisor at 6, trap enable at 5 and pointer at 4:0. Bits 19:13 read as zero.
- R9: trap_valid is high for exactly the one cycle after a trapping command and is low after a command that does not trap.
- R10: A mask write (cmd_op 5) loads the mask from bits NWIN-1:0 of cmd_data and ignores the bits above.
- R11: When cmd_valid is low, no state changes whatever cmd_op holds. cmd_op 0 is a no-op.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 none, 1 save, 2 restore, 3 trap return, 4 status write, 5 mask write |
| cmd_data | input | 32 | Write data for status and mask writes |
| stat_o | output | 32 | Packed status word |
| mask_o | output | NWIN | Window invalid mask |
| trap_valid | output | 1 | One-cycle trap request |
| trap_code | output | 2 | 1 overflow, 2 underflow, 3 illegal |

## Verification
The bench builds the block with NWIN set to 5 and VERSION set to 8'hA3. With five windows, both wrap points fall inside a pointer field wider than needed. Pointer values 5 to 31 are then valid encodings of the write field but illegal window numbers, so the status-write boundary at exactly NWIN can be tested. The 5-bit mask also lets the bench set mask data with high bits that must be dropped.

// File: rtl/win_ptr_ctrl.sv
module win_ptr_ctrl #(
  parameter int NWIN = 8,
  parameter logic [7:0] VERSION = 8'h10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [31:0]     cmd_data,
  output logic [31:0]     stat_o,
  output logic [NWIN-1:0] mask_o,
  output logic            trap_valid,
  output logic [1:0]      trap_code
);
  localparam int CW = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam logic [CW-1:0] TOP = CW'(NWIN - 1);

  localparam logic [2:0] OP_SAVE = 3'd1, OP_REST = 3'd2, OP_RETT = 3'd3,
                         OP_WSTAT = 3'd4, OP_WMASK = 3'd5;
  localparam logic [1:0] TC_OVF = 2'd1, TC_UNF = 2'd2, TC_ILL = 2'd3;

  logic [CW-1:0]   cwp_q;
  logic [NWIN-1:0] wim_q;
  logic [3:0]      icc_q, pil_q;
  logic            ef_q, s_q, ps_q, et_q;
  logic            tv_q;
  logic [1:0]      tc_q;

  logic [CW-1:0] cwp_dn, cwp_up;
  logic          dn_blk, up_blk, wr_bad;
  logic          unused_data;

  assign cwp_dn = (cwp_q == '0) ? TOP : cwp_q - 1'b1;
  assign cwp_up = (cwp_q == TOP) ? '0 : cwp_q + 1'b1;
  assign dn_blk = wim_q[cwp_dn];
  assign up_blk = wim_q[cwp_up];
  assign wr_bad = {27'd0, cmd_data[4:0]} >= NWIN;
  assign unused_data = ^cmd_data;

  assign stat_o = {VERSION, icc_q, 7'd0, ef_q, pil_q, s_q, ps_q, et_q, 5'(cwp_q)};
  assign mask_o = wim_q;
  assign trap_valid = tv_q;
  assign trap_code = tc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp_q <= '0; wim_q <= '0; icc_q <= '0; pil_q <= '0;
      ef_q <= 1'b0; s_q <= 1'b1; ps_q <= 1'b0; et_q <= 1'b0;
      tv_q <= 1'b0; tc_q <= '0;
    end else begin
      tv_q <= 1'b0;
      if (cmd_valid) begin
        case (cmd_op)
          OP_SAVE:
            if (dn_blk) begin tv_q <= 1'b1; tc_q <= TC_OVF; end
            else cwp_q <= cwp_dn;
          OP_REST:
            if (up_blk) begin tv_q <= 1'b1; tc_q <= TC_UNF; end
            else cwp_q <= cwp_up;
          OP_RETT:
            if (et_q) begin tv_q <= 1'b1; tc_q <= TC_ILL; end
            else if (up_blk) begin tv_q <= 1'b1; tc_q <= TC_UNF; end
            else begin cwp_q <= cwp_up; et_q <= 1'b1; s_q <= ps_q; end
          OP_WSTAT:
            if (wr_bad) begin tv_q <= 1'b1; tc_q <= TC_ILL; end
            else begin
              icc_q <= cmd_data[23:20];
              ef_q  <= cmd_data[12];
              pil_q <= cmd_data[11:8];
              s_q   <= cmd_data[7];
              ps_q  <= cmd_data[6];
              et_q  <= cmd_data[5];
              cwp_q <= CW'(cmd_data[4:0]);
            end
          OP_WMASK: wim_q <= cmd_data[NWIN-1:0];
          default: ;
        endcase
      end
    end
  end

  AST_CWP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {{(32-CW){1'b0}}, cwp_q} < NWIN);  // R2
  AST_TRAP_HOLDS_CWP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> $stable(stat_o[4:0]));  // R4
  AST_OVF_FROM_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_code == TC_OVF) |-> $past(cmd_op) == OP_SAVE);  // R4
  AST_ILL_KEEPS_ET: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_code == TC_ILL) |-> $stable(stat_o[5]));  // R5
  AST_TRAP_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> $past(cmd_valid));  // R9
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(stat_o) && $stable(mask_o)));  // R11
endmodule

// File: tb/sim_win_ptr_ctrl.sv
module sim_win_ptr_ctrl;
  localparam int NW = 5;
  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic [31:0] stat_o;
  logic [NW-1:0] mask_o;
  logic trap_valid;
  logic [1:0] trap_code;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  win_ptr_ctrl #(.NWIN(NW), .VERSION(8'hA3)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .stat_o(stat_o), .mask_o(mask_o),
    .trap_valid(trap_valid), .trap_code(trap_code));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [31:0] d, input logic v = 1'b1);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0;
  endtask

  task automatic expect_ok(input string req, input logic [31:0] st);
    chk(req, {31'd0, trap_valid}, 32'd0);
    chk(req, stat_o, st);
  endtask

  task automatic expect_trap(input string req, input logic [1:0] code, input logic [31:0] st);
    chk(req, {31'd0, trap_valid}, 32'd1);
    chk(req, {30'd0, trap_code}, {30'd0, code});
    chk(req, stat_o, st);
  endtask

  task automatic t_reset;
    chk("R1", stat_o, 32'hA300_0080);
    chk("R1", {27'd0, mask_o}, 32'd0);
    chk("R1", {31'd0, trap_valid}, 32'd0);
  endtask

  task automatic t_save;
    cmd(3'd1, 0); expect_ok("R2", 32'hA300_0084);
    cmd(3'd1, 0); expect_ok("R2", 32'hA300_0083);
  endtask

  task automatic t_restore;
    cmd(3'd4, 32'h84); expect_ok("R7", 32'hA300_0084);
    cmd(3'd2, 0); expect_ok("R3", 32'hA300_0080);
    cmd(3'd2, 0); expect_ok("R3", 32'hA300_0081);
  endtask

  task automatic t_mask;
    cmd(3'd4, 32'h80);
    cmd(3'd5, 32'hFFFF_FFE2);
    chk("R10", {27'd0, mask_o}, 32'h02);
    cmd(3'd2, 0); expect_trap("R4", 2'd2, 32'hA300_0080);
    @(negedge clk);
    chk("R9", {31'd0, trap_valid}, 32'd0);
    cmd(3'd4, 32'h82);
    cmd(3'd1, 0); expect_trap("R4", 2'd1, 32'hA300_0082);
    cmd(3'd5, 0);
    chk("R10", {27'd0, mask_o}, 32'd0);
  endtask

  task automatic t_rett;
    cmd(3'd4, 32'h44);
    cmd(3'd3, 0); expect_ok("R6", 32'hA300_00E0);
    cmd(3'd3, 0); expect_trap("R5", 2'd3, 32'hA300_00E0);
    cmd(3'd4, 32'h81);
    cmd(3'd5, 32'h04);
    cmd(3'd3, 0); expect_trap("R6", 2'd2, 32'hA300_0081);
    cmd(3'd5, 0);
  endtask

  task automatic t_wstat;
    cmd(3'd4, 32'hFFFF_FFFF); expect_trap("R7", 2'd3, 32'hA300_0081);
    cmd(3'd4, 32'h0000_0005); expect_trap("R7", 2'd3, 32'hA300_0081);
    cmd(3'd4, 32'h55FF_FBC4); expect_ok("R8", 32'hA3F0_1BC4);
  endtask

  task automatic t_idle;
    cmd(3'd1, 0, 1'b0); expect_ok("R11", 32'hA3F0_1BC4);
    cmd(3'd5, 32'h1F, 1'b0);
    chk("R11", {27'd0, mask_o}, 32'd0);
    cmd(3'd0, 0); expect_ok("R11", 32'hA3F0_1BC4);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset; t_save; t_restore; t_mask; t_rett; t_wstat; t_idle;
      end
      begin
        repeat (5000) @(negedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule